// File: doc/BRIEF.md
# Transport Stream Clock Reference Restamper with Gap Watchdog

This block sits in one downlink's byte-wide transport stream path. It keeps a local network clock reference that advances on a 27 MHz enable. It writes the current value of that reference into the clock reference field of every packet that carries one on a chosen PID. A command port can reload the local reference from a master value. The load is held back until it can be applied cleanly.

The block also measures how many 27 MHz ticks have passed since the last reference packet left it. When that count goes beyond a programmable limit, it raises an error flag. It then replaces the next packet on the stream, whatever that packet holds, with a reference packet it builds itself. Every output byte leaves one clock after the matching input byte.

Top module: `pcr_restamp_top`

## Requirements
- R1: Every input byte leaves one clock later, with its valid and start markers copied. A packet that is not a reference packet leaves with all 188 bytes unchanged.
- R2: The local reference holds a 33-bit base and a 9-bit extension. On each tick the extension steps from 0 to 299 and then wraps to 0, and each wrap adds one to the base. The base wraps from all ones to zero.
- R3: A packet is a reference packet only when three tests all hold: the low 13 bits of bytes 1 and 2 equal `cfg_pid`, bit 5 of byte 3 (adaptation field present) is set, and bit 4 of byte 5 (reference flag) is set. The upper three bits of byte 1 are ignored.
- R4: In a reference packet, bytes 6 to 11 are replaced by the reference value captured when byte 5 is accepted. These six bytes read, most significant first, as the 33-bit base, then six one bits, then the 9-bit extension.
- R5: A pulse on `resync_load` stores `resync_value` (base in bits 41:9, extension in bits 8:0). The stored value becomes the reference on the next tick, not before.
- R6: A pending load is not applied while bytes 6 to 11 of a reference packet are in flight. A tick in that window advances the reference normally, and the load waits for the next tick after the field is done.
- R7: The gap timer counts ticks since the last reference packet. `late_err` rises when the count is strictly greater than `cfg_limit`, and stays low when the count equals the limit.
- R8: While `late_err` is high, the next packet to start is overwritten with a generated reference packet. Its bytes are: 0x47, {3'b000, pid[12:8]}, pid[7:0], 0x20, 183, 0x10, the six reference bytes laid out as in R4, and then 0xFF up to byte 187.
- R9: A reference packet, whether passed through or generated, restarts the gap timer at zero and clears `late_err` when its byte 5 is accepted.
- R10: After reset, the outputs and `late_err` are low, and the local reference is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| in_data | input | 8 | Input stream byte |
| ref_tick | input | 1 | 27 MHz reference enable, one cycle wide |
| resync_load | input | 1 | Load request from the command decoder |
| resync_value | input | 42 | Master reference value {base, extension} |
| cfg_pid | input | 13 | PID that carries clock references |
| cfg_limit | input | TIMER_W | Largest allowed gap in ticks |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is byte 0 of a packet |
| out_data | output | 8 | Output stream byte |
| late_err | output | 1 | Reference gap exceeded |

## Verification
The checker makes several assumptions about the inputs. Packets start with the sync byte 0x47. A start marker is raised only on a valid byte. Every loaded extension is at most 299. `cfg_limit` does not change while the timer is close to the limit. The stimulus respects all of these. It builds packets of exactly 188 bytes with a proper sync byte, loads only legal reference values, and changes the limit only just before a reference packet. Ticks are kept away from packet bytes, except in the one case that deliberately places a tick inside the reference field.

// File: rtl/pcr_restamp_pkg.sv
package pcr_restamp_pkg;

  localparam int BASE_W   = 33;
  localparam int EXT_W    = 9;
  localparam int PCR_W    = BASE_W + EXT_W;
  localparam int PID_W    = 13;
  localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(299);

  localparam logic [7:0] SYNC_BYTE  = 8'h47;
  localparam logic [7:0] STUFF_BYTE = 8'hFF;
  localparam logic [7:0] AFC_ONLY   = 8'h20;
  localparam logic [7:0] FLAG_ONLY  = 8'h10;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [EXT_W-1:0]  ext;
  } pcr_t;

  // Byte k (0..5) of the six-byte reference field.
  function automatic logic [7:0] pcr_byte(input pcr_t v, input logic [2:0] k);
    case (k)
      3'd0:    return v.base[32:25];
      3'd1:    return v.base[24:17];
      3'd2:    return v.base[16:9];
      3'd3:    return v.base[8:1];
      3'd4:    return {v.base[0], 6'h3F, v.ext[8]};
      default: return v.ext[7:0];
    endcase
  endfunction

endpackage

// File: rtl/pcr_local_clock.sv
module pcr_local_clock
  import pcr_restamp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  input  pcr_t load_val,
  input  logic hold,
  output pcr_t now
);

  logic pend_q;
  pcr_t held_q;
  pcr_t stepped;

  always_comb begin
    if (now.ext == EXT_LAST) begin
      stepped.base = now.base + BASE_W'(1);
      stepped.ext  = '0;
    end else begin
      stepped.base = now.base;
      stepped.ext  = now.ext + EXT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now    <= '0;
      pend_q <= 1'b0;
      held_q <= '0;
    end else begin
      if (tick) begin
        if (pend_q && !hold) begin
          now <= held_q;
          if (!load) pend_q <= 1'b0;
        end else begin
          now <= stepped;
        end
      end
      if (load) begin
        pend_q <= 1'b1;
        held_q <= load_val;
      end
    end
  end

endmodule

// File: rtl/pcr_gap_watch.sv
module pcr_gap_watch #(
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               restart,
  input  logic [TIMER_W-1:0] limit,
  output logic [TIMER_W-1:0] gap,
  output logic               late
);

  localparam logic [TIMER_W-1:0] GAP_TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      late <= 1'b0;
    end else if (restart) begin
      gap  <= '0;
      late <= 1'b0;
    end else begin
      if (tick && gap != GAP_TOP) gap <= gap + TIMER_W'(1);
      if (gap > limit) late <= 1'b1;
    end
  end

endmodule

// File: rtl/pcr_field_stamper.sv
module pcr_field_stamper
  import pcr_restamp_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic [PID_W-1:0] cfg_pid,
  input  pcr_t             clk_now,
  input  logic             late,
  output logic             out_valid,
  output logic             out_sop,
  output logic [7:0]       out_data,
  output logic             ref_seen,
  output logic             field_busy
);

  localparam int IW = $clog2(PKT_LEN + 1);
  localparam logic [IW-1:0] I_SYNC   = IW'(0);
  localparam logic [IW-1:0] I_PID_HI = IW'(1);
  localparam logic [IW-1:0] I_PID_LO = IW'(2);
  localparam logic [IW-1:0] I_AFC    = IW'(3);
  localparam logic [IW-1:0] I_LEN    = IW'(4);
  localparam logic [IW-1:0] I_FLAG   = IW'(5);
  localparam logic [IW-1:0] I_F0     = IW'(6);
  localparam logic [IW-1:0] I_F1     = IW'(11);
  localparam logic [IW-1:0] I_MAX    = '1;
  localparam logic [7:0]    AF_LEN_GEN = 8'(PKT_LEN - 5);

  logic [IW-1:0]      idx_q, cur_idx;
  logic [PID_W-9:0]   pid_hi_q;
  logic               pid_ok_q, af_q, ref_q, gen_q;
  logic               gen_now, ref_now, in_field;
  pcr_t               snap_q;
  logic [2:0]         fsel;
  logic [7:0]         stamp_byte, gen_byte, nxt_byte;

  always_comb begin
    cur_idx    = in_sop ? I_SYNC : idx_q;
    gen_now    = in_sop ? late : gen_q;
    ref_now    = pid_ok_q & af_q & in_data[4];
    ref_seen   = in_valid && (cur_idx == I_FLAG) && (gen_now || ref_now);
    in_field   = (cur_idx >= I_F0) && (cur_idx <= I_F1);
    field_busy = ref_q && (idx_q >= I_F0) && (idx_q <= I_F1);
    fsel       = 3'(cur_idx - I_F0);
    stamp_byte = pcr_byte(snap_q, fsel);
    case (cur_idx)
      I_SYNC:   gen_byte = SYNC_BYTE;
      I_PID_HI: gen_byte = 8'(cfg_pid[PID_W-1:8]);
      I_PID_LO: gen_byte = cfg_pid[7:0];
      I_AFC:    gen_byte = AFC_ONLY;
      I_LEN:    gen_byte = AF_LEN_GEN;
      I_FLAG:   gen_byte = FLAG_ONLY;
      default:  gen_byte = in_field ? stamp_byte : STUFF_BYTE;
    endcase
    if (gen_now)              nxt_byte = gen_byte;
    else if (ref_q && in_field) nxt_byte = stamp_byte;
    else                      nxt_byte = in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      pid_hi_q  <= '0;
      pid_ok_q  <= 1'b0;
      af_q      <= 1'b0;
      ref_q     <= 1'b0;
      gen_q     <= 1'b0;
      snap_q    <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sop   <= in_valid & in_sop;
      out_data  <= nxt_byte;
      if (in_valid) begin
        if (cur_idx != I_MAX) idx_q <= cur_idx + IW'(1);
        if (in_sop) gen_q <= late;
        if (cur_idx == I_PID_HI) pid_hi_q <= in_data[PID_W-9:0];
        if (cur_idx == I_PID_LO) pid_ok_q <= ({pid_hi_q, in_data} == cfg_pid);
        if (cur_idx == I_AFC) af_q <= in_data[5];
        if (cur_idx == I_SYNC) ref_q <= 1'b0;
        if (ref_seen) begin
          ref_q  <= 1'b1;
          snap_q <= clk_now;
        end
      end
    end
  end

endmodule

// File: rtl/pcr_restamp_top.sv
module pcr_restamp_top
  import pcr_restamp_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic [7:0]         in_data,
  input  logic               ref_tick,
  input  logic               resync_load,
  input  logic [41:0]        resync_value,
  input  logic [12:0]        cfg_pid,
  input  logic [TIMER_W-1:0] cfg_limit,
  output logic               out_valid,
  output logic               out_sop,
  output logic [7:0]         out_data,
  output logic               late_err
);

  pcr_t               clk_now;
  logic               field_busy;
  logic               ref_seen;
  logic [TIMER_W-1:0] gap_cnt;

  pcr_local_clock u_clock (
    .clk      (clk),
    .rst      (rst),
    .tick     (ref_tick),
    .load     (resync_load),
    .load_val (pcr_t'(resync_value)),
    .hold     (field_busy),
    .now      (clk_now)
  );

  pcr_gap_watch #(.TIMER_W(TIMER_W)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .tick    (ref_tick),
    .restart (ref_seen),
    .limit   (cfg_limit),
    .gap     (gap_cnt),
    .late    (late_err)
  );

  pcr_field_stamper #(.PKT_LEN(PKT_LEN)) u_stamp (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_data    (in_data),
    .cfg_pid    (cfg_pid),
    .clk_now    (clk_now),
    .late       (late_err),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_data   (out_data),
    .ref_seen   (ref_seen),
    .field_busy (field_busy)
  );

endmodule

// File: rtl/pcr_restamp_chk.sv
module pcr_restamp_chk #(
  parameter int TIMER_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               ref_tick,
  input logic               field_busy,
  input logic [41:0]        cnt,
  input logic [TIMER_W-1:0] gap_cnt,
  input logic [TIMER_W-1:0] cfg_limit,
  input logic               late_err,
  input logic               out_valid,
  input logic               out_sop,
  input logic [7:0]         out_data
);

  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (out_valid == $past(in_valid)));

  assert_sync_lead_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop) |-> (out_data == 8'h47));

  assert_ext_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt[8:0] <= 9'd299);

  assert_no_load_in_field_R6: assert property (@(posedge clk) disable iff (rst)
    (field_busy && ref_tick) |=>
      (cnt == (($past(cnt[8:0]) == 9'd299) ? {$past(cnt[41:9]) + 33'd1, 9'd0}
                                           : {$past(cnt[41:9]), $past(cnt[8:0]) + 9'd1})));

  assert_late_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(late_err) |-> $past(gap_cnt > cfg_limit));

endmodule

bind pcr_restamp_top pcr_restamp_chk #(.TIMER_W(TIMER_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .ref_tick   (ref_tick),
  .field_busy (field_busy),
  .cnt        (clk_now),
  .gap_cnt    (gap_cnt),
  .cfg_limit  (cfg_limit),
  .late_err   (late_err),
  .out_valid  (out_valid),
  .out_sop    (out_sop),
  .out_data   (out_data)
);

// File: tb/sim_pcr_restamp_top.sv
module sim_pcr_restamp_top;

  localparam int CLK_NS = 10;
  localparam int PKT    = 188;
  localparam int TW     = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_sop, ref_tick, resync_load;
  logic [7:0]    in_data;
  logic [41:0]   resync_value;
  logic [12:0]   cfg_pid;
  logic [TW-1:0] cfg_limit;
  logic          out_valid, out_sop, late_err;
  logic [7:0]    out_data;

  pcr_restamp_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .ref_tick(ref_tick), .resync_load(resync_load), .resync_value(resync_value),
    .cfg_pid(cfg_pid), .cfg_limit(cfg_limit), .out_valid(out_valid),
    .out_sop(out_sop), .out_data(out_data), .late_err(late_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] pkt [PKT];
  logic [7:0] expb [PKT];
  logic [7:0] obuf [PKT];
  int ocnt = 0;

  logic [32:0] m_base = '0;
  logic [8:0]  m_ext  = '0;
  logic        m_pend = 1'b0;
  logic [41:0] m_val  = '0;

  // {pid16, byte3, byte5, stamped}
  localparam logic [32:0] VEC [7] = '{
    {16'h0123, 8'h30, 8'h10, 1'b1},
    {16'h0124, 8'h30, 8'h10, 1'b0},
    {16'h0123, 8'h10, 8'h10, 1'b0},
    {16'h0123, 8'h30, 8'h00, 1'b0},
    {16'h0123, 8'h20, 8'h50, 1'b1},
    {16'h4123, 8'h31, 8'h90, 1'b1},
    {16'h1123, 8'h30, 8'h10, 1'b0}
  };

  always @(negedge clk) begin
    if (out_valid) begin
      if (out_sop) ocnt = 0;
      if (ocnt < PKT) obuf[ocnt] = out_data;
      ocnt++;
    end
  end

  function automatic logic [7:0] enc(input logic [32:0] b, input logic [8:0] e, input int k);
    logic [47:0] f;
    f = {b, 6'h3F, e};
    return f[47-8*k -: 8];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pkt(input string req);
    int bad_i;
    bad_i = -1;
    for (int i = 0; i < PKT; i++) if (bad_i < 0 && obuf[i] !== expb[i]) bad_i = i;
    n_chk++;
    if (ocnt != PKT) begin
      n_bad++;
      $display("FAIL %s byte count actual=%0d expected=%0d", req, ocnt, PKT);
    end else if (bad_i >= 0) begin
      n_bad++;
      $display("FAIL %s byte %0d actual=%0h expected=%0h", req, bad_i, obuf[bad_i], expb[bad_i]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic make_pkt(input logic [15:0] pid16, input logic [7:0] b3, input logic [7:0] b5);
    for (int i = 0; i < PKT; i++) pkt[i] = 8'(i) ^ 8'h5A;
    pkt[0] = 8'h47; pkt[1] = pid16[15:8]; pkt[2] = pid16[7:0];
    pkt[3] = b3; pkt[4] = 8'd183; pkt[5] = b5;
  endtask

  task automatic exp_pass(input logic stamped);
    for (int i = 0; i < PKT; i++) expb[i] = pkt[i];
    if (stamped) for (int k = 0; k < 6; k++) expb[6+k] = enc(m_base, m_ext, k);
  endtask

  task automatic exp_gen();
    for (int i = 0; i < PKT; i++) expb[i] = 8'hFF;
    expb[0] = 8'h47; expb[1] = {3'b000, cfg_pid[12:8]}; expb[2] = cfg_pid[7:0];
    expb[3] = 8'h20; expb[4] = 8'd183; expb[5] = 8'h10;
    for (int k = 0; k < 6; k++) expb[6+k] = enc(m_base, m_ext, k);
  endtask

  task automatic send(input int ld_at, input int tk_at, input logic [41:0] ld_v);
    for (int i = 0; i < PKT; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_data = pkt[i];
      resync_load = (i == ld_at); resync_value = ld_v;
      ref_tick = (i == tk_at);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; resync_load = 1'b0; ref_tick = 1'b0;
    idle(3);
  endtask

  task automatic m_step();
    if (m_ext == 9'd299) begin m_ext = '0; m_base = m_base + 33'd1; end
    else m_ext = m_ext + 9'd1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
      if (m_pend) begin m_base = m_val[41:9]; m_ext = m_val[8:0]; m_pend = 1'b0; end
      else m_step();
    end
  endtask

  task automatic load(input logic [41:0] v);
    @(negedge clk) begin resync_load = 1'b1; resync_value = v; end
    @(negedge clk) resync_load = 1'b0;
    m_pend = 1'b1; m_val = v;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_sop = 0; in_data = 0; ref_tick = 0;
    resync_load = 0; resync_value = 0; cfg_pid = 13'h0123; cfg_limit = 1000;
    idle(4);
    chk("R10 out_valid in reset", out_valid, 0);
    chk("R10 late_err in reset", late_err, 0);
    rst = 1'b0;
    idle(2);
    chk("R10 late_err after reset", late_err, 0);

    // R10: reference starts at zero
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1); send(-1, -1, '0);
    chk_pkt("R10 R4 zero stamp");

    load({33'h0_1234_5678, 9'd100}); ticks(1);
    foreach (VEC[v]) begin
      make_pkt(VEC[v][32:17], VEC[v][16:9], VEC[v][8:1]);
      exp_pass(VEC[v][0]);
      send(-1, -1, '0);
      chk_pkt(VEC[v][0] ? "R3 R4 stamped vector" : "R1 R3 passthrough vector");
    end

    // R2: extension wrap and base wrap
    load({33'h1_FFFF_FFFF, 9'd298}); ticks(4);
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1); send(-1, -1, '0);
    chk_pkt("R2 wrap stamp");

    // R5: load waits for a tick
    load({33'h0_0ABC_DEF0, 9'd7});
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1); send(-1, -1, '0);
    chk_pkt("R5 not applied before tick");
    ticks(1);
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1); send(-1, -1, '0);
    chk_pkt("R5 applied on tick");

    // R6: load pending, tick inside field advances normally
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1);
    send(7, 9, {33'h0_0000_5555, 9'd42});
    chk_pkt("R6 field with pending load");
    m_pend = 1'b1; m_val = {33'h0_0000_5555, 9'd42}; m_step();
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1); send(-1, -1, '0);
    chk_pkt("R6 tick in field stepped");
    ticks(1);
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1); send(-1, -1, '0);
    chk_pkt("R6 deferred load applied");

    // R7/R8/R9: gap watchdog
    cfg_limit = 5;
    make_pkt(16'h0123, 8'h30, 8'h10); exp_pass(1'b1); send(-1, -1, '0);
    ticks(5); idle(3);
    chk("R7 gap equal to limit", late_err, 0);
    ticks(1); idle(3);
    chk("R7 gap above limit", late_err, 1);
    make_pkt(16'h0200, 8'h10, 8'h00); exp_gen(); send(-1, -1, '0);
    chk_pkt("R8 generated packet");
    chk("R9 error cleared by generated packet", late_err, 0);
    ticks(5); idle(3);
    chk("R9 timer restarted", late_err, 0);
    ticks(1); idle(3);
    chk("R7 second expiry", late_err, 1);
    make_pkt(16'h0123, 8'h30, 8'h10); exp_gen(); send(-1, -1, '0);
    chk_pkt("R8 reference packet also overwritten");
    chk("R9 error cleared again", late_err, 0);

    summary();
    $finish;
  end

endmodule